// File: doc/BRIEF.md
# Boundary Cell Self-Test Engine

This block drives an autonomous test operation on a group of eight input boundary cells and eight output boundary cells. A scannable 11-bit control word chooses one of four operations. The first is signature compression of the sampled inputs, with an optional per-bit mask. The second is pseudo-random pattern generation on the output cells. The third samples the inputs while inverting every output. The fourth is a binary count on the outputs. The test-port controller raises `run_idle` while it sits in its idle state. For each rising TCK edge at which `run_idle` is high, the engine makes exactly one step.

The control word is loaded through the test port like any other data register. A capture places the current word in a private shift chain, and shifts move it out at `tdo` least significant bit first while new bits enter at `tdi`. An update then applies the new word. The operation code lives in a small state machine. Its four states are TOGGLE, COUNT, SIGNATURE and PATTERN. Reset enters SIGNATURE. An update moves the machine to the state named by the scanned code, and every other cycle holds the current state. The mask enable and the mask bits sit in a shadow register beside it.

Top module: `bte_engine`

## Requirements
- R1: After reset the control word reads back as 00000000010 (signature mode, mask off), and both cell groups hold 00000000.
- R2: While `run_idle` is low, neither `in_cells` nor `out_cells` changes.
- R3: A capture loads the control word into the shift chain, and each shift moves it one place toward `tdo`, bit 0 first, with `tdi` entering at bit 10. An update applies the word: bits [1:0] give the operation (00 toggle, 01 count, 10 signature, 11 pattern), bit 2 enables masking, and bits [10:3] hold the mask.
- R4: In signature mode each step loads `in_cells` with {s[6:0], s7^s5^s4^s3} XOR (in_sample AND NOT m), where s is the old `in_cells` and m is the mask when masking is on and zero otherwise. `out_cells` holds.
- R5: In signature mode with masking on, an input bit whose mask bit is 1 has no effect on the signature.
- R6: In pattern mode each step loads `out_cells` with {s[6:0], s7^s5^s4^s3}, where s is the old `out_cells`, or with 00000001 when s is zero. `in_cells` holds.
- R7: In count mode each step adds one to `out_cells`, so 11111111 is followed by 00000000. `in_cells` holds.
- R8: In toggle mode each step inverts every bit of `out_cells` and loads `in_cells` with `in_sample`.
- R9: A new operation code takes effect from the first step after its update, and at most one operation steps per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_idle | input | 1 | High while the controller is in its idle state; enables one step per cycle |
| cap_dr | input | 1 | Capture the control word into the shift chain |
| shift_dr | input | 1 | Shift the chain one place toward tdo |
| upd_dr | input | 1 | Apply the shifted word as the new control word |
| tdi | input | 1 | Serial data into bit 10 of the chain |
| tdo | output | 1 | Serial data from bit 0 of the chain |
| in_sample | input | 8 | Values seen at the eight input pins |
| in_cells | output | 8 | Input cell contents (sample or signature) |
| out_cells | output | 8 | Output cell contents driven to the pins |

## Verification
A wrong mode state or feedback tap corrupts `in_cells` or `out_cells` on the very first step after the error. Because the signature and the pattern each carry their history forward, the difference never heals and stays visible at every later comparison. A shadow mask bit that is wrong shows only when the matching input bit toggles in a masked run, so the masked runs vary the masked bits on every step. A fault in the chain or the update shows on the next capture and readback, one scan length later.

// File: rtl/bte_pkg.sv
package bte_pkg;

    // Operation code carried in the low two bits of the control word.
    typedef enum logic [1:0] {
        OP_TOGGLE    = 2'b00,
        OP_COUNT     = 2'b01,
        OP_SIGNATURE = 2'b10,
        OP_PATTERN   = 2'b11
    } op_e;

    localparam int OP_W      = 2;
    localparam int STEP_N    = 4;

    // One-hot step strobe positions.
    localparam int STEP_TOG  = 0;
    localparam int STEP_CNT  = 1;
    localparam int STEP_SIG  = 2;
    localparam int STEP_PAT  = 3;

endpackage

// File: rtl/bte_lfsr_step.sv
// One combinational step of a shift-left feedback register, with optional
// parallel inputs folded in through a per-bit gate.
module bte_lfsr_step #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    TAPS = 8'hB8
) (
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] par_i,
    input  logic [W-1:0] block_i,
    output logic [W-1:0] next_o
);

    logic [W-1:0] gated;
    logic         fb;

    for (genvar b = 0; b < W; b++) begin : g_gate
        assign gated[b] = par_i[b] & ~block_i[b];
    end

    assign fb     = ^(state_i & TAPS);
    assign next_o = {state_i[W-2:0], fb} ^ gated;

endmodule

// File: rtl/bte_ctl_chain.sv
// Scan chain and shadow for the mask fields of the control word.
module bte_ctl_chain
    import bte_pkg::*;
#(
    parameter int CH    = 8,
    localparam int CTL_W = CH + OP_W + 1
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             cap_dr,
    input  logic             shift_dr,
    input  logic             upd_dr,
    input  logic             tdi,
    input  op_e              op_cur,
    output logic             tdo,
    output logic [CTL_W-1:0] chain_o,
    output logic             mask_en_o,
    output logic [CH-1:0]    mask_o
);

    logic [CTL_W-1:0] chain_q;
    logic             mask_en_q;
    logic [CH-1:0]    mask_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (cap_dr) begin
            chain_q <= {mask_q, mask_en_q, op_cur};
        end else if (shift_dr) begin
            chain_q <= {tdi, chain_q[CTL_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            mask_en_q <= 1'b0;
            mask_q    <= '0;
        end else if (upd_dr) begin
            mask_en_q <= chain_q[OP_W];
            mask_q    <= chain_q[CTL_W-1:OP_W+1];
        end
    end

    assign tdo       = chain_q[0];
    assign chain_o   = chain_q;
    assign mask_en_o = mask_en_q;
    assign mask_o    = mask_q;

endmodule

// File: rtl/bte_mode_fsm.sv
// Operation state machine: the state is the active test operation.
module bte_mode_fsm
    import bte_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  logic              run_idle,
    input  logic              upd_dr,
    input  logic [OP_W-1:0]   code_i,
    output op_e               op_o,
    output logic [STEP_N-1:0] step_o
);

    op_e op_q, op_d;

    // Next state: an update jumps to the scanned code, otherwise hold.
    always_comb begin
        op_d = op_q;
        if (upd_dr) begin
            unique case (code_i)
                2'b00:   op_d = OP_TOGGLE;
                2'b01:   op_d = OP_COUNT;
                2'b10:   op_d = OP_SIGNATURE;
                2'b11:   op_d = OP_PATTERN;
                default: op_d = OP_SIGNATURE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_SIGNATURE;
        end else begin
            op_q <= op_d;
        end
    end

    // Outputs: one step strobe for the current state while idle is held.
    always_comb begin
        step_o = '0;
        if (run_idle) begin
            unique case (op_q)
                OP_TOGGLE:    step_o[STEP_TOG] = 1'b1;
                OP_COUNT:     step_o[STEP_CNT] = 1'b1;
                OP_SIGNATURE: step_o[STEP_SIG] = 1'b1;
                OP_PATTERN:   step_o[STEP_PAT] = 1'b1;
                default:      step_o = '0;
            endcase
        end
    end

    assign op_o = op_q;

endmodule

// File: rtl/bte_cells.sv
// Input and output boundary cell registers.
module bte_cells
    import bte_pkg::*;
#(
    parameter int CH = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic [STEP_N-1:0] step_i,
    input  logic [CH-1:0]     sample_i,
    input  logic [CH-1:0]     sig_next_i,
    input  logic [CH-1:0]     pat_next_i,
    output logic [CH-1:0]     in_q_o,
    output logic [CH-1:0]     out_q_o
);

    localparam logic [CH-1:0] SEED_ONE = {{(CH-1){1'b0}}, 1'b1};

    logic [CH-1:0] in_q, out_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (step_i[STEP_TOG]) begin
            in_q <= sample_i;
        end else if (step_i[STEP_SIG]) begin
            in_q <= sig_next_i;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (step_i[STEP_TOG]) begin
            out_q <= ~out_q;
        end else if (step_i[STEP_CNT]) begin
            out_q <= out_q + SEED_ONE;
        end else if (step_i[STEP_PAT]) begin
            out_q <= (out_q == '0) ? SEED_ONE : pat_next_i;
        end
    end

    assign in_q_o  = in_q;
    assign out_q_o = out_q;

endmodule

// File: rtl/bte_engine.sv
module bte_engine
    import bte_pkg::*;
#(
    parameter int           CH   = 8,
    parameter logic [CH-1:0] TAPS = 8'hB8
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          run_idle,
    input  logic          cap_dr,
    input  logic          shift_dr,
    input  logic          upd_dr,
    input  logic          tdi,
    output logic          tdo,
    input  logic [CH-1:0] in_sample,
    output logic [CH-1:0] in_cells,
    output logic [CH-1:0] out_cells
);

    localparam int CTL_W = CH + OP_W + 1;

    logic [CTL_W-1:0]  chain;
    logic              mask_en;
    logic [CH-1:0]     mask;
    logic [CH-1:0]     block;
    op_e               op_q;
    logic [STEP_N-1:0] step_vec;
    logic [CH-1:0]     sig_next, pat_next;

    bte_ctl_chain #(.CH(CH)) u_chain (
        .tck       (tck),
        .rst_n     (rst_n),
        .cap_dr    (cap_dr),
        .shift_dr  (shift_dr),
        .upd_dr    (upd_dr),
        .tdi       (tdi),
        .op_cur    (op_q),
        .tdo       (tdo),
        .chain_o   (chain),
        .mask_en_o (mask_en),
        .mask_o    (mask)
    );

    bte_mode_fsm u_fsm (
        .tck      (tck),
        .rst_n    (rst_n),
        .run_idle (run_idle),
        .upd_dr   (upd_dr),
        .code_i   (chain[OP_W-1:0]),
        .op_o     (op_q),
        .step_o   (step_vec)
    );

    assign block = mask_en ? mask : '0;

    bte_lfsr_step #(.W(CH), .TAPS(TAPS)) u_sig (
        .state_i (in_cells),
        .par_i   (in_sample),
        .block_i (block),
        .next_o  (sig_next)
    );

    bte_lfsr_step #(.W(CH), .TAPS(TAPS)) u_pat (
        .state_i (out_cells),
        .par_i   ('0),
        .block_i ('0),
        .next_o  (pat_next)
    );

    bte_cells #(.CH(CH)) u_cells (
        .tck        (tck),
        .rst_n      (rst_n),
        .step_i     (step_vec),
        .sample_i   (in_sample),
        .sig_next_i (sig_next),
        .pat_next_i (pat_next),
        .in_q_o     (in_cells),
        .out_q_o    (out_cells)
    );

endmodule

// File: rtl/bte_engine_chk.sv
module bte_engine_chk #(
    parameter int CH = 8
) (
    input logic          tck,
    input logic          rst_n,
    input logic          run_idle,
    input logic [CH-1:0] in_sample,
    input logic [CH-1:0] in_cells,
    input logic [CH-1:0] out_cells,
    input logic [3:0]    steps,
    input logic [1:0]    op
);

    a_r2_hold_out: assert property (@(posedge tck) disable iff (!rst_n)
        !run_idle |=> $stable(out_cells));

    a_r2_hold_in: assert property (@(posedge tck) disable iff (!rst_n)
        !run_idle |=> $stable(in_cells));

    a_r9_one_step: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(steps) && (run_idle == (steps != 4'b0)));

    a_r8_toggle: assert property (@(posedge tck) disable iff (!rst_n)
        (run_idle && op == 2'b00) |=>
            (out_cells == ~$past(out_cells)) && (in_cells == $past(in_sample)));

    a_r7_count: assert property (@(posedge tck) disable iff (!rst_n)
        (run_idle && op == 2'b01) |=>
            (out_cells == $past(out_cells) + 1'b1) && $stable(in_cells));

    a_r4_sig_out_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (run_idle && op == 2'b10) |=> $stable(out_cells));

    a_r6_pattern_nonzero: assert property (@(posedge tck) disable iff (!rst_n)
        (run_idle && op == 2'b11) |=> (out_cells != '0) && $stable(in_cells));

endmodule

bind bte_engine bte_engine_chk #(.CH(CH)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .run_idle  (run_idle),
    .in_sample (in_sample),
    .in_cells  (in_cells),
    .out_cells (out_cells),
    .steps     (step_vec),
    .op        (op_q)
);

// File: tb/bte_engine_bench.sv
module bte_engine_bench;

    localparam int CLK_PERIOD = 10;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_idle = 1'b0;
    logic       cap_dr = 1'b0;
    logic       shift_dr = 1'b0;
    logic       upd_dr = 1'b0;
    logic       tdi = 1'b0;
    logic       tdo;
    logic [7:0] in_sample = 8'h00;
    logic [7:0] in_cells, out_cells;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state.
    logic [1:0] m_op   = 2'b10;
    logic       m_men  = 1'b0;
    logic [7:0] m_mask = 8'h00;
    logic [7:0] m_in   = 8'h00;
    logic [7:0] m_out  = 8'h00;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    bte_engine u_bte_engine (
        .tck(tck), .rst_n(rst_n), .run_idle(run_idle), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
        .in_sample(in_sample), .in_cells(in_cells), .out_cells(out_cells)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    function automatic logic [7:0] shl_fb(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected cell pair per cycle and compares.
    always @(negedge tck) begin
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {in_cells, out_cells}, exp_q.pop_front());
        end
    end

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
    task automatic step(input logic run, input logic [7:0] smp);
        string tag;
        run_idle  = run;
        in_sample = smp;
        tag = "R2 hold";
        if (run) begin
            case (m_op)
                2'b00: begin m_out = ~m_out; m_in = smp; tag = "R8 toggle"; end
                2'b01: begin
                    tag = (m_out == 8'hFF) ? "R7 wrap" : "R7 count";
                    m_out = m_out + 8'd1;
                end
                2'b10: begin
                    m_in = shl_fb(m_in) ^ (smp & ~(m_men ? m_mask : 8'h00));
                    tag = m_men ? "R5 masked signature" : "R4 signature";
                end
                default: begin
                    tag = (m_out == 8'h00) ? "R6 zero seed" : "R6 pattern";
                    m_out = (m_out == 8'h00) ? 8'h01 : shl_fb(m_out);
                end
            endcase
        end
        exp_q.push_back({m_in, m_out});
        tag_q.push_back(tag);
        @(negedge tck); #1;
    endtask

    task automatic scan_ctl(input logic [10:0] nv, output logic [10:0] ov);
        run_idle = 1'b0;
        cap_dr = 1'b1;
        @(negedge tck); #1;
        cap_dr = 1'b0;
        shift_dr = 1'b1;
        for (int i = 0; i < 11; i++) begin
            ov[i] = tdo;
            tdi = nv[i];
            @(negedge tck); #1;
        end
        shift_dr = 1'b0;
        upd_dr = 1'b1;
        @(negedge tck); #1;
        upd_dr = 1'b0;
        m_op = nv[1:0]; m_men = nv[2]; m_mask = nv[10:3];
    endtask

    initial begin
        logic [10:0] rb;
        repeat (3) @(negedge tck);
        #1 rst_n = 1'b1;
        check("R1 reset cells", {in_cells, out_cells}, 16'h0000);
        scan_ctl(11'h002, rb);
        check("R1 reset control word", {5'b0, rb}, {5'b0, 11'h002});

        for (int i = 0; i < 16; i++) step(1'b1, 8'(i * 29 + 7));
        for (int i = 0; i < 4; i++)  step(1'b0, 8'(i * 53 + 1));

        // Masked signature: upper nibble blocked, varied every step.
        scan_ctl({8'hF0, 1'b1, 2'b10}, rb);
        check("R3 readback after reset", {5'b0, rb}, {5'b0, 11'h002});
        for (int i = 0; i < 16; i++) step(1'b1, {4'(i * 7 + 3), 4'(i)});

        // Pattern from an all-zero output group.
        scan_ctl({8'h00, 1'b0, 2'b11}, rb);
        check("R3 readback of masked word", {5'b0, rb}, {5'b0, 8'hF0, 1'b1, 2'b10});
        for (int i = 0; i < 20; i++) step(1'b1, 8'hA5);
        for (int i = 0; i < 3; i++)  step(1'b0, 8'h5A);

        // Count across the wrap point.
        scan_ctl({8'h3C, 1'b0, 2'b01}, rb);
        check("R9 mode code readback", {14'b0, rb[1:0]}, 16'h0003);
        for (int i = 0; i < 300; i++) step(1'b1, 8'h00);

        scan_ctl({8'h81, 1'b1, 2'b00}, rb);
        check("R3 readback of count word", {5'b0, rb}, {5'b0, 8'h3C, 1'b0, 2'b01});
        for (int i = 0; i < 6; i++) step(1'b1, 8'(i * 91 + 17));
        step(1'b0, 8'hFF);

        scan_ctl(11'h002, rb);
        check("R3 readback of toggle word", {5'b0, rb}, {5'b0, 8'h81, 1'b1, 2'b00});
        for (int i = 0; i < 8; i++) step(1'b1, 8'(i * 13 + 200));

        run_idle = 1'b0;
        @(negedge tck); #1;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule